// File: doc/BRIEF.md
# GPIO Pin Bank with Input Polarity and Output Blink

This block is a bank of general-purpose I/O pins, 32 by default, that software controls through a small register bus. Each pin is set as an input or an output by its bit in a direction register. An output pin drives the level stored in the output-level register. If that pin's bit in the blink register is set, the pin drives a square wave instead. All blinking pins share one square wave, and its half period comes from a free-running prescaler.

On the input side, every pad is resynchronised into the core clock domain through a chain of flops. A per-pin polarity bit is then applied: the pin reads as-is when the bit is clear and inverted when it is set. The result is read from a read-only data-in register. A pin that is configured as an input has its pad driver disabled.

The bus is a plain single-cycle port with address, write strobe, write data and a combinational read-data return. The register at address N always uses bit k for pin k.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset, the direction register reads all ones and the output-level, blink and polarity registers read zero. With every pad input low, the data-in register reads zero and every pad driver is disabled.
- R2: Direction bit 1 makes a pin an input, and its `pad_oe` bit is then 0. Direction bit 0 makes it an output, and its `pad_oe` bit is then 1. A direction write takes effect on `pad_oe` in the cycle after the write edge.
- R3: A pin whose blink bit is 0 drives its output-level register bit on `pad_out`.
- R4: Data-in bit k equals the synchronised pad k when polarity bit k is 0, and its inverse when polarity bit k is 1. A polarity write takes effect on data-in right after the write edge.
- R5: A pad change appears in data-in only after two rising clock edges. After one edge the old value is still read.
- R6: A pin whose blink bit is 1 ignores its output-level bit. Its `pad_out` toggles every `BLINK_HALF` cycles, in phase with every other blinking pin.
- R7: Clearing a blink bit returns that pin to its static output level.
- R8: Register addresses are 0 direction, 1 output level, 2 blink, 3 polarity and 4 data-in. Addresses 0 to 3 read back the last value written. A write to address 4 changes no register and does not alter data-in.
- R9: Addresses 5 to 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad driver enables, 1 drives |

## Verification
The hardest behaviour to pin down from the ports is blinking. The prescaler runs freely from reset and no register exposes it, so the bench cannot predict in which cycle a blinking pin toggles. The bench therefore overrides the half period to a small value and watches two blinking pins for many cycles. It measures the distance between transitions, requires both pins to stay equal even though their static bits differ, and checks that a non-blinking neighbour holds steady. Synchronizer latency is reached by changing the pads and reading data-in at zero, one and two edges after the change.

// File: rtl/gpio_pin_bank_pkg.sv
package gpio_pin_bank_pkg;
   // Register addresses; the pin number selects the bit within each register.
   localparam int ADR_DIR   = 0;
   localparam int ADR_OUT   = 1;
   localparam int ADR_BLINK = 2;
   localparam int ADR_POL   = 3;
   localparam int ADR_DIN   = 4;
   localparam int ADR_LAST  = ADR_DIN;
   localparam int MAX_PINS  = 32;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
   parameter int HALF_PERIOD = 500000
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

   if (HALF_PERIOD < 2) begin : g_bad_half
      $error("gpio_blink_timer: HALF_PERIOD must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign phase = phase_q;

   // R6: the shared blink wave only changes when a full half period has elapsed
   a_r6_phase_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
   import gpio_pin_bank_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [NPINS-1:0]  bus_wdata,
   input  logic [NPINS-1:0]  din,
   output logic [NPINS-1:0]  bus_rdata,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  out_q,
   output logic [NPINS-1:0]  blink_q,
   output logic [NPINS-1:0]  pol_q
);
   logic wr_dir, wr_out, wr_blink, wr_pol;

   assign wr_dir   = bus_we && (bus_addr == ADDR_W'(ADR_DIR));
   assign wr_out   = bus_we && (bus_addr == ADDR_W'(ADR_OUT));
   assign wr_blink = bus_we && (bus_addr == ADDR_W'(ADR_BLINK));
   assign wr_pol   = bus_we && (bus_addr == ADDR_W'(ADR_POL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '1;
         out_q   <= '0;
         blink_q <= '0;
         pol_q   <= '0;
      end else begin
         if (wr_dir)   dir_q   <= bus_wdata;
         if (wr_out)   out_q   <= bus_wdata;
         if (wr_blink) blink_q <= bus_wdata;
         if (wr_pol)   pol_q   <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if      (bus_addr == ADDR_W'(ADR_DIR))   bus_rdata = dir_q;
      else if (bus_addr == ADDR_W'(ADR_OUT))   bus_rdata = out_q;
      else if (bus_addr == ADDR_W'(ADR_BLINK)) bus_rdata = blink_q;
      else if (bus_addr == ADDR_W'(ADR_POL))   bus_rdata = pol_q;
      else if (bus_addr == ADDR_W'(ADR_DIN))   bus_rdata = din;
   end

   // R8: a write to the data-in address leaves every writable register alone
   a_r8_din_readonly: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(ADR_DIN)) |=>
         ($stable(dir_q) && $stable(out_q) && $stable(blink_q) && $stable(pol_q)));

   // R9: writes to unmapped addresses leave every register alone
   a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr > ADDR_W'(ADR_LAST)) |=>
         ($stable(dir_q) && $stable(out_q) && $stable(blink_q) && $stable(pol_q)));
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
   import gpio_pin_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int BLINK_HALF  = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [NPINS-1:0]  bus_wdata,
   output logic [NPINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe
);
   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
      $error("gpio_pin_bank: NPINS out of range");
   end
   if ((1 << ADDR_W) <= ADR_LAST) begin : g_bad_addr
      $error("gpio_pin_bank: ADDR_W too narrow for the register map");
   end

   logic [NPINS-1:0] dir_q, out_q, blink_q, pol_q;
   logic [NPINS-1:0] sync_q, din;
   logic             blink_phase;

   gpio_sync_chain #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pad_in),
      .q_sync  (sync_q)
   );

   gpio_blink_timer #(.HALF_PERIOD(BLINK_HALF)) u_blink (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (blink_phase)
   );

   gpio_ctrl_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .din       (din),
      .bus_rdata (bus_rdata),
      .dir_q     (dir_q),
      .out_q     (out_q),
      .blink_q   (blink_q),
      .pol_q     (pol_q)
   );

   assign din = sync_q ^ pol_q;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign pad_oe[p]  = ~dir_q[p];
      assign pad_out[p] = blink_q[p] ? blink_phase : out_q[p];
   end

   // R2: a direction write shows up inverted on the pad enables one cycle later
   a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(ADR_DIR)) |=> pad_oe == ~$past(bus_wdata));

   // R7: with no pin blinking and static levels unchanged, the pads hold still
   a_r7_static_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (blink_q == '0 && $past(blink_q) == '0 && $stable(out_q)) |-> $stable(pad_out));
endmodule

// File: tb/gpio_pin_bank_test.sv
`timescale 1ns/1ps
module gpio_pin_bank_test;
   localparam int HALF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, pad_in, pad_out, pad_oe;

   initial pad_in = '0;
   always #2.5 clk = ~clk;

   gpio_pin_bank #(.NPINS(32), .ADDR_W(3), .SYNC_STAGES(2), .BLINK_HALF(HALF)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   typedef struct {
      int          kind;   // 0 read data, 1 pad_out, 2 pad_oe
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int vectors = 0;
   int miscompares = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Monitor: compares one expected item per cycle, away from the rising edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         case (it.kind)
            0:       check(it.req, bus_rdata, it.exp);
            1:       check(it.req, pad_out, it.exp);
            default: check(it.req, pad_oe, it.exp);
         endcase
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string req);
      item_t it;
      bus_addr = a;
      it.kind = 0; it.exp = e; it.req = req;
      q.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic expect_pad(input int kind, input logic [31:0] e, input string req);
      item_t it;
      it.kind = kind; it.exp = e; it.req = req;
      q.push_back(it);
      @(posedge clk); #1;
   endtask

   // Watches the blinking pins 0 and 1 and the static pin 2
   task automatic observe_blink(input logic pin2_exp);
      int last_change = -1;
      int intervals = 0;
      int bad_iv = 0;
      int bad_pair = 0;
      int bad_static = 0;
      logic prev;
      @(negedge clk);
      prev = pad_out[0];
      for (int i = 0; i < 8 * HALF; i++) begin
         @(negedge clk);
         if (pad_out[1] !== pad_out[0]) bad_pair++;
         if (pad_out[2] !== pin2_exp) bad_static++;
         if (pad_out[0] !== prev) begin
            if (last_change >= 0) begin
               intervals++;
               if (i - last_change != HALF) bad_iv++;
            end
            last_change = i;
            prev = pad_out[0];
         end
      end
      check("R6 toggle interval errors", bad_iv, 0);
      check("R6 intervals seen (>=5)", (intervals >= 5) ? 32'd1 : 32'd0, 32'd1);
      check("R6 shared phase pin0/pin1 mismatches", bad_pair, 0);
      check("R3 static neighbour disturbed", bad_static, 0);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      expect_rd(3'd0, 32'hFFFF_FFFF, "R1 direction reset");
      expect_rd(3'd1, 32'h0, "R1 output reset");
      expect_rd(3'd2, 32'h0, "R1 blink reset");
      expect_rd(3'd3, 32'h0, "R1 polarity reset");
      expect_rd(3'd4, 32'h0, "R1 data-in reset");
      expect_pad(2, 32'h0, "R1 pad_oe reset");

      // R2 direction
      bus_write(3'd0, 32'hFFFF_0000);
      expect_pad(2, 32'h0000_FFFF, "R2 pad_oe after direction write");
      expect_rd(3'd0, 32'hFFFF_0000, "R8 direction readback");

      // R3 static output
      bus_write(3'd1, 32'h0000_A5C3);
      expect_pad(1, 32'h0000_A5C3, "R3 pad_out static level");
      expect_rd(3'd1, 32'h0000_A5C3, "R8 output readback");

      // R5 synchronizer latency, R4 polarity clear
      pad_in = 32'h1234_5678;
      expect_rd(3'd4, 32'h0, "R5 data-in before any edge");
      expect_rd(3'd4, 32'h0, "R5 data-in after one edge");
      expect_rd(3'd4, 32'h1234_5678, "R5 data-in after two edges");
      expect_rd(3'd4, 32'h1234_5678, "R4 polarity clear passes pad");

      // R4 polarity set
      bus_write(3'd3, 32'hFFFF_0000);
      expect_rd(3'd4, 32'hEDCB_5678, "R4 polarity inverts upper half");
      expect_rd(3'd3, 32'hFFFF_0000, "R8 polarity readback");

      // R8 data-in ignores writes
      bus_write(3'd4, 32'hFFFF_FFFF);
      expect_rd(3'd4, 32'hEDCB_5678, "R8 data-in unchanged by write");
      expect_rd(3'd0, 32'hFFFF_0000, "R8 direction unchanged by data-in write");
      expect_rd(3'd1, 32'h0000_A5C3, "R8 output unchanged by data-in write");

      // R9 unmapped addresses
      bus_write(3'd6, 32'h5A5A_5A5A);
      expect_rd(3'd6, 32'h0, "R9 unmapped address 6 reads zero");
      expect_rd(3'd5, 32'h0, "R9 unmapped address 5 reads zero");
      expect_rd(3'd7, 32'h0, "R9 unmapped address 7 reads zero");
      expect_rd(3'd0, 32'hFFFF_0000, "R9 direction unchanged");
      expect_rd(3'd1, 32'h0000_A5C3, "R9 output unchanged");
      expect_rd(3'd2, 32'h0, "R9 blink unchanged");
      expect_rd(3'd3, 32'hFFFF_0000, "R9 polarity unchanged");

      // R6 blink on pins 0 and 1; pin 1's static bit cleared, so it is ignored
      bus_write(3'd1, 32'h0000_A5C1);
      bus_write(3'd2, 32'h0000_0003);
      expect_rd(3'd2, 32'h0000_0003, "R8 blink readback");
      observe_blink(1'b0);

      // R7 blink off returns to static levels
      bus_write(3'd2, 32'h0);
      expect_pad(1, 32'h0000_A5C1, "R7 static level restored");
      expect_pad(1, 32'h0000_A5C1, "R7 static level held");

      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule